// File: doc/BRIEF.md
# Dual-Supply Undervoltage Supervisor

This block watches two power rails through comparator flags and decides when each of two channel sequencers may run. One flag reports whether the higher of the two rails is above the main lockout threshold. Two further flags, one per rail, report whether each rail is above its low-rail threshold. Every flag is filtered in time against a 1 µs timebase strobe, so that short dips are ignored. The block drives a registered supply-good level and a one-cycle fault-clear pulse for each channel.

There are two tiers of supervision. A low-rail fault is local: it stops and clears only its own channel, and that channel becomes good again as soon as its rail recovers. A main-rail fault is global: it stops and clears both channels. After that, the main rail must stay good for a long qualification delay before either channel is released. When both rails sit above the main threshold, the main flag does not move, so a dip on one rail resets only its own channel. All delays are parameters counted in timebase ticks.

Top module: `dual_rail_uv_sup`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it is released, both `supply_good_o` bits and both `fault_clr_o` bits are 0.
- R2: `supply_good_o` can only be 1 once `main_ok_i` has been sampled high on QUAL_TICKS consecutive tick cycles. Good rises at the edge that samples the last of those ticks. A low sample of `main_ok_i` before that point restarts the count.
- R3: If `main_ok_i` is sampled low on MAIN_FILT_TICKS+1 consecutive tick cycles, then at the edge that samples the last of them both `supply_good_o` bits fall and both `fault_clr_o` bits pulse.
- R4: A low run of `main_ok_i` of at most MAIN_FILT_TICKS ticks is ignored. The filter restarts whenever the flag is sampled high.
- R5: If `rail_ok_i[c]` is sampled low on RAIL_FILT_TICKS+1 consecutive tick cycles, then at that edge `supply_good_o[c]` falls and `fault_clr_o[c]` pulses. Bit c of every vector belongs to channel c, and the other channel is unaffected.
- R6: A low run of `rail_ok_i[c]` of at most RAIL_FILT_TICKS ticks is ignored.
- R7: After a low-rail fault on channel c, with the main rail still qualified, `supply_good_o[c]` returns to 1 at the first edge that samples `rail_ok_i[c]` high. No qualification delay applies.
- R8: After a main-rail fault, both channels stay low until `main_ok_i` has again been high for QUAL_TICKS ticks.
- R9: Each `fault_clr_o` bit is a single-cycle pulse. When the main filter and a rail filter expire at the same edge, each channel gets exactly one pulse.
- R10: Filter and qualification counters advance only on cycles with `tick_i` high. A low flag held while `tick_i` stays 0 causes no fault.
- R11: `srst_i` sampled high drives both `supply_good_o` bits to 0 at that edge and restarts the qualification. Good returns QUAL_TICKS ticks after `srst_i` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous restart of the qualification; holds supply-good low |
| tick_i | input | 1 | 1 µs timebase strobe, one cycle wide |
| main_ok_i | input | 1 | Higher rail above the main lockout threshold |
| rail_ok_i | input | NUM_CH | Per-rail flag: rail above its low-rail threshold |
| supply_good_o | output | NUM_CH | Per-channel supply-good level, registered |
| fault_clr_o | output | NUM_CH | Per-channel fault-latch clear pulse, one cycle |

## Verification
The main-rail filter and a low-rail filter can expire on the same edge. Each of them would then request a clear pulse and a supply-good drop for the same channel. The bench provokes this by lowering the main flag first and the channel-0 rail flag MAIN_FILT_TICKS-RAIL_FILT_TICKS ticks later, so that both filters expire together. The result is judged by counting pulses per channel across the whole window (exactly one each) and by seeing both good bits fall at that exact edge, not one cycle later.

// File: rtl/uvs_pkg.sv
package uvs_pkg;
  typedef struct packed {
    logic hit;
    logic bad;
    logic bad_next;
  } flt_s;
endpackage

// File: rtl/uvs_filter.sv
module uvs_filter
  import uvs_pkg::*;
#(
  parameter int unsigned FILT_TICKS = 8,
  parameter bit          START_BAD  = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ok_i,
  output flt_s flt_o
);
  localparam int unsigned LIM = FILT_TICKS + 1;
  localparam int unsigned CW  = $clog2(LIM + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t LIM_C  = cnt_t'(LIM);
  localparam cnt_t FILT_C = cnt_t'(FILT_TICKS);

  cnt_t cnt_q, cnt_d;
  logic hit;

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (ok_i) begin
      cnt_d = '0;
    end else if (tick_i && cnt_q != LIM_C) begin
      cnt_d = cnt_q + cnt_t'(1);
      hit   = (cnt_q == FILT_C);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= START_BAD ? LIM_C : '0;
    else         cnt_q <= cnt_d;
  end

  assign flt_o.hit      = hit;
  assign flt_o.bad      = (cnt_q == LIM_C);
  assign flt_o.bad_next = (cnt_d == LIM_C);
endmodule

// File: rtl/uvs_qual.sv
module uvs_qual #(
  parameter int unsigned QUAL_TICKS = 160000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ok_i,
  input  logic kill_i,
  input  logic srst_i,
  output logic up_o,
  output logic up_next_o
);
  localparam int unsigned CW = $clog2(QUAL_TICKS + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t LAST_C = cnt_t'(QUAL_TICKS - 1);

  cnt_t cnt_q, cnt_d;
  logic up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (srst_i || kill_i) begin
      cnt_d = '0;
      up_d  = 1'b0;
    end else if (!up_q) begin
      if (!ok_i) begin
        cnt_d = '0;
      end else if (tick_i) begin
        if (cnt_q == LAST_C) begin
          up_d  = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + cnt_t'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign up_o      = up_q;
  assign up_next_o = up_d;
endmodule

// File: rtl/dual_rail_uv_sup.sv
module dual_rail_uv_sup
  import uvs_pkg::*;
#(
  parameter int unsigned NUM_CH          = 2,
  parameter int unsigned MAIN_FILT_TICKS = 12,
  parameter int unsigned RAIL_FILT_TICKS = 8,
  parameter int unsigned QUAL_TICKS      = 160000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              tick_i,
  input  logic              main_ok_i,
  input  logic [NUM_CH-1:0] rail_ok_i,
  output logic [NUM_CH-1:0] supply_good_o,
  output logic [NUM_CH-1:0] fault_clr_o
);
  flt_s main_flt;
  logic main_hit;
  logic main_up_q, main_up_d;
  logic [NUM_CH-1:0] good_d, clr_d;
  logic [NUM_CH-1:0] good_q, clr_q;

  uvs_filter #(.FILT_TICKS(MAIN_FILT_TICKS), .START_BAD(1'b0)) u_main_flt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .ok_i  (main_ok_i),
    .flt_o (main_flt)
  );
  assign main_hit = main_flt.hit;

  uvs_qual #(.QUAL_TICKS(QUAL_TICKS)) u_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ok_i     (main_ok_i),
    .kill_i   (main_hit),
    .srst_i   (srst_i),
    .up_o     (main_up_q),
    .up_next_o(main_up_d)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    flt_s rail_flt;
    // rails start faulted so a channel never runs on an unseen rail
    uvs_filter #(.FILT_TICKS(RAIL_FILT_TICKS), .START_BAD(1'b1)) u_rail_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick_i),
      .ok_i  (rail_ok_i[c]),
      .flt_o (rail_flt)
    );
    assign good_d[c] = main_up_d & ~rail_flt.bad_next & ~srst_i;
    assign clr_d[c]  = rail_flt.hit | main_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q <= '0;
      clr_q  <= '0;
    end else begin
      good_q <= good_d;
      clr_q  <= clr_d;
    end
  end

  assign supply_good_o = good_q;
  assign fault_clr_o   = clr_q;
endmodule

// File: rtl/uvs_chk.sv
module uvs_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              srst_i,
  input logic              main_hit_i,
  input logic              main_up_i,
  input logic [NUM_CH-1:0] supply_good_o,
  input logic [NUM_CH-1:0] fault_clr_o
);
  // R11
  srst_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (supply_good_o == '0));

  // R3
  main_clr_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_hit_i |=> (fault_clr_o == {NUM_CH{1'b1}}));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // R9
    clr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_clr_o[c] |=> !fault_clr_o[c]);

    // R5
    clr_drops_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_clr_o[c] |-> !supply_good_o[c]);

    // R2
    good_needs_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      supply_good_o[c] |-> main_up_i);
  end
endmodule

bind dual_rail_uv_sup uvs_chk #(.NUM_CH(NUM_CH)) u_uvs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srst_i       (srst_i),
  .main_hit_i   (main_hit),
  .main_up_i    (main_up_q),
  .supply_good_o(supply_good_o),
  .fault_clr_o  (fault_clr_o)
);

// File: tb/dual_rail_uv_sup_test.sv
module dual_rail_uv_sup_test;
  localparam int MF = 12;
  localparam int RF = 8;
  localparam int QT = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic       tick = 1'b1;
  logic       main_ok = 1'b1;
  logic [1:0] rail_ok = 2'b11;
  logic [1:0] good, clr;

  int checks = 0;
  int failures = 0;
  int clr_cnt0 = 0;
  int clr_cnt1 = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_rail_uv_sup #(
    .NUM_CH(2), .MAIN_FILT_TICKS(MF), .RAIL_FILT_TICKS(RF), .QUAL_TICKS(QT)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .tick_i(tick),
    .main_ok_i(main_ok), .rail_ok_i(rail_ok),
    .supply_good_o(good), .fault_clr_o(clr)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      clr_cnt0 = clr_cnt0 + int'(clr[0]);
      clr_cnt1 = clr_cnt1 + int'(clr[1]);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 good in reset", int'(good), 0);
    chk("R1 clr in reset", int'(clr), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 good after release", int'(good), 0);
    chk("R1 clr after release", int'(clr), 0);
  endtask

  task automatic t_qual();
    step(8);
    main_ok = 1'b0;
    step(1);
    main_ok = 1'b1;
    step(QT - 1);
    chk("R2 good before qual end", int'(good), 0);
    step(1);
    chk("R2 good at qual end", int'(good), 3);
  endtask

  task automatic t_main_glitch();
    int b0 = clr_cnt0, b1 = clr_cnt1;
    main_ok = 1'b0;
    step(MF);
    chk("R4 good after max dip", int'(good), 3);
    main_ok = 1'b1;
    step(1);
    main_ok = 1'b0;
    step(MF);
    main_ok = 1'b1;
    step(1);
    chk("R4 good after two dips", int'(good), 3);
    chk("R4 no clr", clr_cnt0 - b0 + clr_cnt1 - b1, 0);
  endtask

  task automatic t_main_fault();
    main_ok = 1'b0;
    step(MF);
    chk("R3 good one tick early", int'(good), 3);
    step(1);
    chk("R3 good at fault", int'(good), 0);
    chk("R3 clr both", int'(clr), 3);
    step(1);
    chk("R9 clr pulse ends", int'(clr), 0);
    step(5);
  endtask

  task automatic t_requal();
    main_ok = 1'b1;
    step(QT - 1);
    chk("R8 good before requal", int'(good), 0);
    step(1);
    chk("R8 good after requal", int'(good), 3);
  endtask

  task automatic t_rail_fault();
    int b1 = clr_cnt1;
    rail_ok = 2'b10;
    step(RF);
    chk("R6 good before rail fault", int'(good), 3);
    step(1);
    chk("R5 own good drops", int'(good), 2);
    chk("R5 own clr only", int'(clr), 1);
    step(1);
    chk("R9 rail clr ends", int'(clr), 0);
    step(20);
    chk("R5 other channel no clr", clr_cnt1 - b1, 0);
    chk("R5 other channel good", int'(good), 2);
  endtask

  task automatic t_rail_recover();
    rail_ok = 2'b11;
    step(1);
    chk("R7 good back at once", int'(good), 3);
  endtask

  task automatic t_rail_glitch();
    int b0 = clr_cnt0, b1 = clr_cnt1;
    rail_ok = 2'b01;
    step(RF);
    rail_ok = 2'b11;
    step(1);
    rail_ok = 2'b10;
    step(RF);
    rail_ok = 2'b11;
    step(1);
    chk("R6 good after rail dips", int'(good), 3);
    chk("R6 no clr", clr_cnt0 - b0 + clr_cnt1 - b1, 0);
  endtask

  task automatic t_tick_gate();
    int b0 = clr_cnt0;
    tick = 1'b0;
    rail_ok = 2'b10;
    main_ok = 1'b0;
    step(40);
    chk("R10 good without ticks", int'(good), 3);
    chk("R10 no clr without ticks", clr_cnt0 - b0, 0);
    rail_ok = 2'b11;
    main_ok = 1'b1;
    step(1);
    tick = 1'b1;
    step(1);
    chk("R10 good after tick restore", int'(good), 3);
  endtask

  task automatic t_collide();
    int b0 = clr_cnt0, b1 = clr_cnt1;
    main_ok = 1'b0;
    step(MF - RF);
    rail_ok = 2'b10;
    step(RF);
    chk("R9 good before joint expiry", int'(good), 3);
    step(1);
    chk("R9 good at joint expiry", int'(good), 0);
    chk("R9 clr at joint expiry", int'(clr), 3);
    step(10);
    chk("R9 ch0 single pulse", clr_cnt0 - b0, 1);
    chk("R9 ch1 single pulse", clr_cnt1 - b1, 1);
    main_ok = 1'b1;
    rail_ok = 2'b11;
    step(QT);
    chk("R8 good after collision requal", int'(good), 3);
  endtask

  task automatic t_srst();
    srst = 1'b1;
    step(1);
    chk("R11 good drops on srst", int'(good), 0);
    srst = 1'b0;
    step(QT - 1);
    chk("R11 good before requal", int'(good), 0);
    step(1);
    chk("R11 good after requal", int'(good), 3);
  endtask

  initial begin
    t_reset();
    t_qual();
    t_main_glitch();
    t_main_fault();
    t_requal();
    t_rail_fault();
    t_rail_recover();
    t_rail_glitch();
    t_tick_gate();
    t_collide();
    t_srst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule